// File: doc/BRIEF.md
# PTP Timestamp Capture Register Unit

This unit samples a free-running 63-bit time counter when a transmit or receive PTP event pulse arrives, and keeps one stored value per direction. Software reads each stored value as two 32-bit read-only words through a plain register read port: an address, a read strobe and a read data bus that returns the selected word on the cycle after the strobe.

The two directions use different rules to make the split read consistent. On the transmit side, reading the low word freezes the stored value, and reading the high word releases it. While the value is frozen, any transmit event is thrown away. On the receive side, a flag in the top bit of the high word marks a fresh capture, and reading the high word clears that flag. A policy input decides whether a new receive event may replace a capture that software has not yet read. A 16-bit receive sequence identifier is latched together with each receive capture.

Top module: `ptp_stamp_capture`

## Requirements
- R1: After reset, every readable word returns zero, the receive fresh flag is 0 and the transmit value is not frozen.
- R2: A transmit event captures `time_now` when the value is not frozen. Address 0 returns bits 31:0 of the capture. Address 1 returns bit 31 as 0 and bits 30:0 as capture bits 62:32.
- R3: A read of address 0 freezes the transmit capture. A transmit event that arrives in the same cycle as that read, or while the capture is frozen, is discarded and is not held for later.
- R4: A read of address 1 releases the freeze, and a transmit event after that read is captured again.
- R5: A receive event that is allowed to capture stores `time_now` and `rx_seq_id`, and sets the fresh flag. Address 2 returns capture bits 31:0. Address 3 returns capture bits 62:32 in bits 30:0.
- R6: Address 3 returns the fresh flag in bit 31. Reading address 3 clears the flag unless a receive capture happens in the same cycle.
- R7: When `rx_lock_policy` is 1 and the fresh flag is set, a receive event is dropped. The stored time and the stored sequence ID stay unchanged.
- R8: When `rx_lock_policy` is 0, a receive event overwrites the stored time and sequence ID even if the fresh flag is set, and the flag stays set.
- R9: Address 4 returns the stored sequence ID in bits 15:0 and zero in bits 31:16. Addresses 5 to 7 return zero.
- R10: `rd_data` changes only on the clock edge that samples `rd_en` high, and then presents the selected word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| time_now | input | 63 | Free-running time counter value |
| tx_event | input | 1 | One-cycle transmit capture pulse |
| rx_event | input | 1 | One-cycle receive capture pulse |
| rx_seq_id | input | 16 | Sequence identifier that goes with the receive event |
| rx_lock_policy | input | 1 | 1: keep an unread receive capture; 0: allow overwrite |
| rd_en | input | 1 | Read strobe |
| rd_addr | input | 3 | Word select: 0 tx low, 1 tx high, 2 rx low, 3 rx high, 4 rx sequence |
| rd_data | output | 32 | Read word, valid on the cycle after the strobe |

## Verification
The assertions check the cycle rules on every clock. These rules are: a frozen transmit capture stays constant, a low read sets the freeze, a high read clears it, a locked receive capture stays constant, an allowed receive event loads time and sequence ID and sets the flag, a high read clears the flag, and the read data matches the stored state. Some behaviour shows up only in the bench scenarios. These are the full low-then-high read order on both sides, the proof that a discarded transmit event is really lost rather than delayed, the difference between the two policy settings seen through the port, and the zero fill of reserved and unmapped words.

// File: rtl/ptp_stamp_pkg.sv
`timescale 1ns/1ps
package ptp_stamp_pkg;
  localparam int ADDR_W = 3;
  typedef logic [ADDR_W-1:0] addr_t;
  localparam addr_t ADDR_TX_LO  = 3'd0;
  localparam addr_t ADDR_TX_HI  = 3'd1;
  localparam addr_t ADDR_RX_LO  = 3'd2;
  localparam addr_t ADDR_RX_HI  = 3'd3;
  localparam addr_t ADDR_RX_SEQ = 3'd4;
endpackage

// File: rtl/ptp_rst_sync.sv
`timescale 1ns/1ps
// Asynchronous assert, synchronous release.
module ptp_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_n_sync = chain_q[STAGES-1];
endmodule

// File: rtl/ptp_tx_slot.sv
`timescale 1ns/1ps
// Transmit capture with freeze: low read freezes, high read releases.
module ptp_tx_slot #(
  parameter int TS_W = 63
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [TS_W-1:0] time_now,
  input  logic            tx_event,
  input  logic            lo_rd,
  input  logic            hi_rd,
  output logic [TS_W-1:0] stamp,
  output logic            frozen
);
  logic [TS_W-1:0] stamp_q, stamp_d;
  logic            frozen_q, frozen_d;
  logic            capture;

  always_comb begin
    // an event in the freezing read cycle is dropped so the read stays coherent
    capture  = tx_event & ~frozen_q & ~lo_rd;
    stamp_d  = capture ? time_now : stamp_q;
    frozen_d = frozen_q;
    if (lo_rd)      frozen_d = 1'b1;
    else if (hi_rd) frozen_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stamp_q  <= '0;
      frozen_q <= 1'b0;
    end else begin
      stamp_q  <= stamp_d;
      frozen_q <= frozen_d;
    end
  end

  assign stamp  = stamp_q;
  assign frozen = frozen_q;
endmodule

// File: rtl/ptp_rx_slot.sv
`timescale 1ns/1ps
// Receive capture with fresh flag and overwrite policy.
module ptp_rx_slot #(
  parameter int TS_W  = 63,
  parameter int SEQ_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [TS_W-1:0]  time_now,
  input  logic [SEQ_W-1:0] seq_in,
  input  logic             rx_event,
  input  logic             lock_policy,
  input  logic             hi_rd,
  output logic [TS_W-1:0]  stamp,
  output logic [SEQ_W-1:0] seq,
  output logic             fresh
);
  logic [TS_W-1:0]  stamp_q, stamp_d;
  logic [SEQ_W-1:0] seq_q, seq_d;
  logic             fresh_q, fresh_d;
  logic             capture;

  always_comb begin
    capture = rx_event & ~(lock_policy & fresh_q);
    stamp_d = capture ? time_now : stamp_q;
    seq_d   = capture ? seq_in   : seq_q;
    fresh_d = fresh_q;
    if (capture)    fresh_d = 1'b1;
    else if (hi_rd) fresh_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stamp_q <= '0;
      seq_q   <= '0;
      fresh_q <= 1'b0;
    end else begin
      stamp_q <= stamp_d;
      seq_q   <= seq_d;
      fresh_q <= fresh_d;
    end
  end

  assign stamp = stamp_q;
  assign seq   = seq_q;
  assign fresh = fresh_q;
endmodule

// File: rtl/ptp_rd_mux.sv
`timescale 1ns/1ps
// Registered read-back: loads the selected word on a read strobe, holds otherwise.
module ptp_rd_mux
  import ptp_stamp_pkg::*;
#(
  parameter int TS_W   = 63,
  parameter int WORD_W = 32,
  parameter int SEQ_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_en,
  input  addr_t             rd_addr,
  input  logic [TS_W-1:0]   tx_stamp,
  input  logic [TS_W-1:0]   rx_stamp,
  input  logic [SEQ_W-1:0]  rx_seq,
  input  logic              rx_fresh,
  output logic [WORD_W-1:0] rd_data
);
  // high word carries the TS_W-WORD_W upper bits under one flag bit
  localparam int HI_W = TS_W - WORD_W;

  logic [WORD_W-1:0] data_q, data_d, word_sel;

  always_comb begin
    case (rd_addr)
      ADDR_TX_LO:  word_sel = tx_stamp[WORD_W-1:0];
      ADDR_TX_HI:  word_sel = {1'b0, tx_stamp[TS_W-1:WORD_W]};
      ADDR_RX_LO:  word_sel = rx_stamp[WORD_W-1:0];
      ADDR_RX_HI:  word_sel = {rx_fresh, rx_stamp[WORD_W+HI_W-1:WORD_W]};
      ADDR_RX_SEQ: word_sel = {{(WORD_W-SEQ_W){1'b0}}, rx_seq};
      default:     word_sel = '0;
    endcase
    data_d = rd_en ? word_sel : data_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) data_q <= '0;
    else        data_q <= data_d;
  end

  assign rd_data = data_q;
endmodule

// File: rtl/ptp_stamp_capture.sv
`timescale 1ns/1ps
module ptp_stamp_capture
  import ptp_stamp_pkg::*;
#(
  parameter int TS_W   = 63,
  parameter int WORD_W = 32,
  parameter int SEQ_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [TS_W-1:0]   time_now,
  input  logic              tx_event,
  input  logic              rx_event,
  input  logic [SEQ_W-1:0]  rx_seq_id,
  input  logic              rx_lock_policy,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [WORD_W-1:0] rd_data
);
  logic             rst_n_s;
  logic             tx_lo_rd, tx_hi_rd, rx_hi_rd;
  logic [TS_W-1:0]  tx_stamp, rx_stamp;
  logic [SEQ_W-1:0] rx_seq;
  logic             tx_frozen, rx_fresh;

  assign tx_lo_rd = rd_en & (rd_addr == ADDR_TX_LO);
  assign tx_hi_rd = rd_en & (rd_addr == ADDR_TX_HI);
  assign rx_hi_rd = rd_en & (rd_addr == ADDR_RX_HI);

  ptp_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_n_sync(rst_n_s)
  );

  ptp_tx_slot #(.TS_W(TS_W)) u_tx (
    .clk(clk), .rst_n(rst_n_s), .time_now(time_now), .tx_event(tx_event),
    .lo_rd(tx_lo_rd), .hi_rd(tx_hi_rd), .stamp(tx_stamp), .frozen(tx_frozen)
  );

  ptp_rx_slot #(.TS_W(TS_W), .SEQ_W(SEQ_W)) u_rx (
    .clk(clk), .rst_n(rst_n_s), .time_now(time_now), .seq_in(rx_seq_id),
    .rx_event(rx_event), .lock_policy(rx_lock_policy), .hi_rd(rx_hi_rd),
    .stamp(rx_stamp), .seq(rx_seq), .fresh(rx_fresh)
  );

  ptp_rd_mux #(.TS_W(TS_W), .WORD_W(WORD_W), .SEQ_W(SEQ_W)) u_rd (
    .clk(clk), .rst_n(rst_n_s), .rd_en(rd_en), .rd_addr(rd_addr),
    .tx_stamp(tx_stamp), .rx_stamp(rx_stamp), .rx_seq(rx_seq),
    .rx_fresh(rx_fresh), .rd_data(rd_data)
  );
endmodule

// File: rtl/ptp_stamp_capture_chk.sv
`timescale 1ns/1ps
module ptp_stamp_capture_chk
  import ptp_stamp_pkg::*;
#(
  parameter int TS_W   = 63,
  parameter int WORD_W = 32,
  parameter int SEQ_W  = 16
) (
  input logic              clk,
  input logic              rst_n_s,
  input logic [TS_W-1:0]   time_now,
  input logic              tx_event,
  input logic              rx_event,
  input logic [SEQ_W-1:0]  rx_seq_id,
  input logic              rx_lock_policy,
  input logic              rd_en,
  input logic [ADDR_W-1:0] rd_addr,
  input logic [WORD_W-1:0] rd_data,
  input logic [TS_W-1:0]   tx_stamp,
  input logic [TS_W-1:0]   rx_stamp,
  input logic [SEQ_W-1:0]  rx_seq,
  input logic              tx_frozen,
  input logic              rx_fresh
);
  // R2
  tx_capture_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    (tx_event && !tx_frozen && !(rd_en && rd_addr == ADDR_TX_LO)) |=> tx_stamp == $past(time_now));
  // R3
  tx_freeze_set_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    (rd_en && rd_addr == ADDR_TX_LO) |=> tx_frozen);
  // R3
  tx_frozen_hold_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    tx_frozen |=> $stable(tx_stamp));
  // R4
  tx_release_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    (rd_en && rd_addr == ADDR_TX_HI) |=> !tx_frozen);
  // R5
  rx_capture_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    (rx_event && !(rx_lock_policy && rx_fresh)) |=>
      (rx_fresh && rx_stamp == $past(time_now) && rx_seq == $past(rx_seq_id)));
  // R6
  rx_flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    (rd_en && rd_addr == ADDR_RX_HI && !rx_event) |=> !rx_fresh);
  // R7
  rx_lock_hold_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    (rx_lock_policy && rx_fresh) |=> ($stable(rx_stamp) && $stable(rx_seq)));
  // R9
  seq_reserved_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    (rd_en && rd_addr == ADDR_RX_SEQ) |=> rd_data[WORD_W-1:SEQ_W] == '0);
  // R10
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    !rd_en |=> $stable(rd_data));
  // R2
  tx_lo_read_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    (rd_en && rd_addr == ADDR_TX_LO) |=> rd_data == $past(tx_stamp[WORD_W-1:0]));
endmodule

bind ptp_stamp_capture ptp_stamp_capture_chk #(.TS_W(TS_W), .WORD_W(WORD_W), .SEQ_W(SEQ_W)) u_chk (
  .clk(clk), .rst_n_s(rst_n_s), .time_now(time_now), .tx_event(tx_event),
  .rx_event(rx_event), .rx_seq_id(rx_seq_id), .rx_lock_policy(rx_lock_policy),
  .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .tx_stamp(tx_stamp),
  .rx_stamp(rx_stamp), .rx_seq(rx_seq), .tx_frozen(tx_frozen), .rx_fresh(rx_fresh)
);

// File: tb/ptp_stamp_capture_bench.sv
`timescale 1ns/1ps
module ptp_stamp_capture_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [62:0] time_now;
  logic        tx_event, rx_event, rx_lock_policy, rd_en;
  logic [15:0] rx_seq_id;
  logic [2:0]  rd_addr;
  logic [31:0] rd_data;

  always #5 clk = ~clk;

  ptp_stamp_capture u_ptp_stamp_capture (
    .clk(clk), .rst_n(rst_n), .time_now(time_now), .tx_event(tx_event),
    .rx_event(rx_event), .rx_seq_id(rx_seq_id), .rx_lock_policy(rx_lock_policy),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data)
  );

  logic [31:0] exp_q[$];
  string       tag_q[$];
  int          checks = 0;
  int          errors = 0;
  logic        pend = 1'b0;
  bit          done = 1'b0;

  // scoreboard monitor: a read sampled at a posedge is compared at the next negedge
  always @(posedge clk) pend <= rd_en;

  always @(negedge clk) begin
    if (pend) begin
      logic [31:0] e;
      string       t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      checks++;
      if (rd_data !== e) begin
        errors++;
        $display("FAIL %s actual %h expected %h", t, rd_data, e);
      end
    end
  end

  task automatic do_read(input logic [2:0] a, input logic [31:0] e, input string t);
    exp_q.push_back(e);
    tag_q.push_back(t);
    rd_addr = a;
    rd_en   = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    @(negedge clk);
  endtask

  task automatic tx_pulse(input logic [62:0] t);
    time_now = t;
    tx_event = 1'b1;
    @(negedge clk);
    tx_event = 1'b0;
    @(negedge clk);
  endtask

  task automatic rx_pulse(input logic [62:0] t, input logic [15:0] s, input logic pol);
    time_now       = t;
    rx_seq_id      = s;
    rx_lock_policy = pol;
    rx_event       = 1'b1;
    @(negedge clk);
    rx_event = 1'b0;
    @(negedge clk);
  endtask

  logic [62:0] t1, t2, ra, rb;

  initial begin
    rst_n = 1'b0; time_now = '0; tx_event = 0; rx_event = 0;
    rx_seq_id = '0; rx_lock_policy = 1'b1; rd_en = 0; rd_addr = '0;
    t1 = 63'h7234_5678_9ABC_DEF0;
    t2 = 63'h0111_2222_3333_4444;
    ra = 63'h5A5A_0001_CAFE_0002;
    rb = 63'h2468_ACE0_1357_9BDF;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    for (int a = 0; a < 5; a++) do_read(3'(a), 32'h0, "R1 reset word");

    // transmit: capture, freeze on low read, event dropped, release on high read
    tx_pulse(t1);
    do_read(3'd0, t1[31:0], "R2 tx low");
    tx_pulse(t2);
    do_read(3'd1, {1'b0, t1[62:32]}, "R3 tx high kept while frozen");
    do_read(3'd0, t1[31:0], "R3 dropped tx event not queued");
    do_read(3'd1, {1'b0, t1[62:32]}, "R4 release read");
    tx_pulse(t2);
    do_read(3'd0, t2[31:0], "R4 tx low after release");
    do_read(3'd1, {1'b0, t2[62:32]}, "R4 tx high after release");

    // receive: capture, flag read and clear
    rx_pulse(ra, 16'hBEEF, 1'b1);
    do_read(3'd2, ra[31:0], "R5 rx low");
    do_read(3'd4, 32'h0000_BEEF, "R9 seq word");
    do_read(3'd3, {1'b1, ra[62:32]}, "R6 rx high flag set");
    do_read(3'd3, {1'b0, ra[62:32]}, "R6 rx high flag cleared");

    // locked policy: second event dropped
    rx_pulse(rb, 16'h0001, 1'b1);
    rx_pulse(ra, 16'h0002, 1'b1);
    do_read(3'd2, rb[31:0], "R7 rx low kept");
    do_read(3'd4, 32'h0000_0001, "R7 seq kept");
    do_read(3'd3, {1'b1, rb[62:32]}, "R7 rx high kept");

    // overwrite policy: second event replaces, flag stays
    rx_pulse(ra, 16'h0010, 1'b0);
    rx_pulse(rb, 16'h0020, 1'b0);
    do_read(3'd2, rb[31:0], "R8 rx low overwritten");
    do_read(3'd4, 32'h0000_0020, "R8 seq overwritten");
    do_read(3'd3, {1'b1, rb[62:32]}, "R8 flag still set");

    do_read(3'd7, 32'h0, "R9 unmapped word");
    do_read(3'd5, 32'h0, "R9 unmapped word 5");

    // R10: output holds while no strobe
    repeat (3) @(negedge clk);
    checks++;
    if (rd_data !== 32'h0) begin
      errors++;
      $display("FAIL R10 hold actual %h expected %h", rd_data, 32'h0);
    end

    repeat (2) @(negedge clk);
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule